// File: doc/BRIEF.md
# Composite-Field AES Forward Substitution Box

This block computes the forward byte substitution of the AES cipher without a lookup table. It is purely combinational: an 8-bit value enters, and the substituted 8-bit value leaves in the same cycle. The result can be registered by whatever surrounds it, such as a round datapath or a key expansion unit.

Internally the byte is carried into a tower representation of GF(2^8). There it is split into two GF(2^4) halves, and each of those into two GF(2^2) digits, all in normal bases. The multiplicative inverse is formed in that representation. It uses a GF(2^4) square-and-scale unit, one GF(2^4) inverter and three GF(2^4) multipliers. The GF(2^4) inverter is itself three GF(2^2) multipliers and a few XORs. The only non-linear gates sit inside the GF(2^2) multipliers. A single output matrix then performs the return to the standard basis and the linear part of the AES affine step together, and the constant 0x63 is added.

Both basis matrices are derived at elaboration from the tower arithmetic. The block searches for a root of the AES reduction polynomial, which gives the input matrix. It then inverts that mapping and folds in the affine matrix, which gives the output matrix. No hand-entered matrix exists.

Top module: `aes_tower_sbox`

## Requirements
- R1: The output depends only on the present input. A change on `sbox_in` shows on `sbox_out` with no clock edge between them.
- R2: Input 0x00, which has no inverse, gives the output 0x63. That is the affine constant applied to a zero inverse.
- R3: For every nonzero input x, the output is A(x^-1) XOR 0x63. Here x^-1 is the inverse modulo x^8+x^4+x^3+x+1 (0x11B). A maps bit i to b[i]^b[(i+4)%8]^b[(i+5)%8]^b[(i+6)%8]^b[(i+7)%8], with bit 0 as the least significant.
- R4: The following spot values hold: 0x01 gives 0x7C, 0x53 gives 0xED, 0x80 gives 0xCD, 0xFF gives 0x16 and 0x10 gives 0xCA.
- R5: The mapping is a permutation: the 256 inputs give 256 distinct outputs.
- R6: No input maps to itself, and no input maps to its bitwise complement.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sbox_in | input | 8 | Byte to substitute, standard polynomial basis |
| sbox_out | output | 8 | Substituted byte, standard polynomial basis |

## Verification
The assertions assume that the input is a settled two-state byte whenever the combinational block evaluates. They also assume that every value in the full 8-bit range is legal, so no input is excluded. The checks in the inverters multiply their input by their output with an independent tower multiplier and demand the tower unit element. The checks at the top and in the inverter relate zero at one point to zero at the next. The stimulus drives every byte value once per clock, holding each value stable over the sampling point. It then changes the input mid-cycle to show that the result follows with no clock edge.

// File: rtl/aes_tower_pkg.sv
package aes_tower_pkg;

  localparam int PAIR_W = 2;
  localparam int NIB_W  = 2 * PAIR_W;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int FIELD_N = 1 << BYTE_W;

  typedef logic [PAIR_W-1:0] gf4_t;
  typedef logic [NIB_W-1:0]  gf16_t;
  typedef logic [BYTE_W-1:0] gf256_t;
  typedef logic [BYTE_W-1:0][BYTE_W-1:0] bmat_t;

  localparam gf256_t AFF_CONST = 8'h63;

  // Normal bases: unit element has every coefficient set.
  localparam gf16_t  NIB_ONE   = '1;
  localparam gf256_t BYTE_ONE  = '1;

  // Square-scale constant for GF(2^8) over GF(2^4): W in the low (Y^4) digit.
  localparam gf16_t  SQ_LAMBDA = 4'b0010;

  // GF(2^2), bit1 = coefficient of W, bit0 = coefficient of W^2.
  function automatic gf4_t gf4_mul(input gf4_t a, input gf4_t b);
    logic t;
    t = (a[1] ^ a[0]) & (b[1] ^ b[0]);
    return {(a[1] & b[1]) ^ t, (a[0] & b[0]) ^ t};
  endfunction

  function automatic gf4_t gf4_sq(input gf4_t a);
    return {a[0], a[1]};
  endfunction

  // Multiply by W^2 (the GF(2^4) extension constant).
  function automatic gf4_t gf4_scl_nu(input gf4_t a);
    return {a[1] ^ a[0], a[1]};
  endfunction

  // Multiply by W.
  function automatic gf4_t gf4_scl_w(input gf4_t a);
    return {a[0], a[1] ^ a[0]};
  endfunction

  // GF(2^4) over GF(2^2), hi digit = Y coefficient, lo digit = Y^4 coefficient.
  function automatic gf16_t gf16_mul(input gf16_t a, input gf16_t b);
    gf4_t t;
    t = gf4_scl_nu(gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]));
    return {gf4_mul(a[3:2], b[3:2]) ^ t, gf4_mul(a[1:0], b[1:0]) ^ t};
  endfunction

  // GF(2^8) over GF(2^4), hi nibble = Z coefficient, lo nibble = Z^16 coefficient.
  function automatic gf256_t gf256_mul(input gf256_t a, input gf256_t b);
    gf16_t t;
    t = gf16_mul(SQ_LAMBDA, gf16_mul(a[7:4] ^ a[3:0], b[7:4] ^ b[3:0]));
    return {gf16_mul(a[7:4], b[7:4]) ^ t, gf16_mul(a[3:0], b[3:0]) ^ t};
  endfunction

  function automatic gf256_t mat_apply(input bmat_t m, input gf256_t v);
    gf256_t acc;
    acc = '0;
    for (int j = 0; j < BYTE_W; j++)
      if (v[j]) acc ^= m[j];
    return acc;
  endfunction

  function automatic gf256_t affine_lin(input gf256_t v);
    gf256_t r;
    for (int i = 0; i < BYTE_W; i++)
      r[i] = v[i] ^ v[(i+4)%BYTE_W] ^ v[(i+5)%BYTE_W] ^ v[(i+6)%BYTE_W] ^ v[(i+7)%BYTE_W];
    return r;
  endfunction

  // Tower image of the standard generator x: a root of x^8+x^4+x^3+x+1.
  function automatic gf256_t tower_root();
    gf256_t c, c2, c3, c4, c8, p, found;
    logic   hit;
    hit   = 1'b0;
    found = '0;
    for (int k = 1; k < FIELD_N; k++) begin
      c  = gf256_t'(k);
      c2 = gf256_mul(c, c);
      c3 = gf256_mul(c2, c);
      c4 = gf256_mul(c2, c2);
      c8 = gf256_mul(c4, c4);
      p  = c8 ^ c4 ^ c3 ^ c ^ BYTE_ONE;
      if (!hit && p == '0) begin
        hit   = 1'b1;
        found = c;
      end
    end
    return found;
  endfunction

  // Column j = tower image of standard basis bit j.
  function automatic bmat_t fwd_matrix();
    bmat_t  m;
    gf256_t beta, acc;
    beta = tower_root();
    acc  = BYTE_ONE;
    for (int i = 0; i < BYTE_W; i++) begin
      m[i] = acc;
      acc  = gf256_mul(acc, beta);
    end
    return m;
  endfunction

  // Column j = affine-linear image of the standard value whose tower form is bit j.
  function automatic bmat_t ret_matrix();
    bmat_t  fm, m;
    gf256_t t;
    fm = fwd_matrix();
    m  = '0;
    for (int v = 0; v < FIELD_N; v++) begin
      t = mat_apply(fm, gf256_t'(v));
      for (int j = 0; j < BYTE_W; j++)
        if (t == (gf256_t'(1) << j)) m[j] = affine_lin(gf256_t'(v));
    end
    return m;
  endfunction

endpackage

// File: rtl/sbx_linmap.sv
module sbx_linmap
  import aes_tower_pkg::*;
#(
  parameter bmat_t  COLS = '0,
  parameter gf256_t OFS  = '0
) (
  input  logic [BYTE_W-1:0] x,
  output logic [BYTE_W-1:0] y
);
  gf256_t term [BYTE_W];

  for (genvar j = 0; j < BYTE_W; j++) begin : g_col
    assign term[j] = x[j] ? COLS[j] : '0;
  end

  always_comb begin
    y = OFS;
    for (int j = 0; j < BYTE_W; j++) y ^= term[j];
  end
endmodule

// File: rtl/sbx_gf16_mul.sv
module sbx_gf16_mul
  import aes_tower_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  input  logic [NIB_W-1:0] b,
  output logic [NIB_W-1:0] q
);
  gf4_t ph, pl, ps;

  always_comb begin
    ph = gf4_mul(a[3:2], b[3:2]);
    pl = gf4_mul(a[1:0], b[1:0]);
    ps = gf4_scl_nu(gf4_mul(a[3:2] ^ a[1:0], b[3:2] ^ b[1:0]));
    q  = {ph ^ ps, pl ^ ps};
  end
endmodule

// File: rtl/sbx_gf16_sqscl.sv
module sbx_gf16_sqscl
  import aes_tower_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  output logic [NIB_W-1:0] q
);
  // lambda * a^2 with lambda = W*Y^4: hi = (ah+al)^2, lo = W*al^2.
  always_comb q = {gf4_sq(a[3:2] ^ a[1:0]), gf4_scl_w(gf4_sq(a[1:0]))};
endmodule

// File: rtl/sbx_gf16_inv.sv
module sbx_gf16_inv
  import aes_tower_pkg::*;
(
  input  logic [NIB_W-1:0] a,
  output logic [NIB_W-1:0] q
);
  gf4_t hi, lo, theta, d;

  always_comb begin
    hi    = a[3:2];
    lo    = a[1:0];
    theta = gf4_mul(hi, lo) ^ gf4_scl_nu(gf4_sq(hi ^ lo));
    d     = gf4_sq(theta);
    q     = {gf4_mul(d, lo), gf4_mul(d, hi)};
  end

  always_comb begin
    assert_nib_inverse_R3: assert (a == '0 || gf16_mul(a, q) == NIB_ONE)
      else $error("nibble inverse wrong for %h", a);
  end
endmodule

// File: rtl/sbx_gf256_inv.sv
module sbx_gf256_inv
  import aes_tower_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  output logic [BYTE_W-1:0] q
);
  gf16_t sum_n, sq_n, cross_n, theta, d, q_hi, q_lo;

  assign sum_n = a[7:4] ^ a[3:0];

  sbx_gf16_sqscl u_sqscl (.a(sum_n), .q(sq_n));
  sbx_gf16_mul   u_cross (.a(a[7:4]), .b(a[3:0]), .q(cross_n));

  assign theta = cross_n ^ sq_n;

  sbx_gf16_inv   u_ninv  (.a(theta), .q(d));
  sbx_gf16_mul   u_hi    (.a(d), .b(a[3:0]), .q(q_hi));
  sbx_gf16_mul   u_lo    (.a(d), .b(a[7:4]), .q(q_lo));

  assign q = {q_hi, q_lo};

  always_comb begin
    assert_byte_inverse_R3: assert (a == '0 || gf256_mul(a, q) == BYTE_ONE)
      else $error("byte inverse wrong for %h", a);
    assert_zero_inverse_R2: assert ((a == '0) == (q == '0))
      else $error("zero handling wrong for %h", a);
  end
endmodule

// File: rtl/aes_tower_sbox.sv
module aes_tower_sbox
  import aes_tower_pkg::*;
(
  input  logic [7:0] sbox_in,
  output logic [7:0] sbox_out
);
  localparam bmat_t FWD_MAP = fwd_matrix();
  localparam bmat_t RET_MAP = ret_matrix();

  gf256_t tw_in, tw_inv;

  sbx_linmap #(.COLS(FWD_MAP), .OFS('0)) u_fwd (.x(sbox_in), .y(tw_in));
  sbx_gf256_inv u_inv (.a(tw_in), .q(tw_inv));
  sbx_linmap #(.COLS(RET_MAP), .OFS(AFF_CONST)) u_ret (.x(tw_inv), .y(sbox_out));

  always_comb begin
    assert_zero_to_const_R2: assert (sbox_in != '0 || sbox_out == AFF_CONST)
      else $error("zero input gave %h", sbox_out);
    assert_fwd_bijective_R5: assert ((sbox_in == '0) == (tw_in == '0))
      else $error("input map collapsed %h", sbox_in);
    assert_no_fixed_point_R6: assert (sbox_out != sbox_in && sbox_out != ~sbox_in)
      else $error("fixed point at %h", sbox_in);
  end
endmodule

// File: tb/sim_aes_tower_sbox.sv
module sim_aes_tower_sbox;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  aes_tower_sbox u0 (.sbox_in(din), .sbox_out(dout));

  function automatic logic [7:0] pmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = '0; x = a; y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1B : 8'h00);
      y = y >> 1;
    end
    return p;
  endfunction

  function automatic logic [7:0] pinv(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h01;
    if (a == 8'h00) return 8'h00;
    for (int i = 0; i < 254; i++) r = pmul(r, a);
    return r;
  endfunction

  function automatic logic [7:0] ref_sbox(input logic [7:0] x);
    logic [7:0] v, r;
    v = pinv(x);
    for (int i = 0; i < 8; i++)
      r[i] = v[i] ^ v[(i+4)%8] ^ v[(i+5)%8] ^ v[(i+6)%8] ^ v[(i+7)%8];
    return r ^ 8'h63;
  endfunction

  task automatic check(input string req, input logic [7:0] x,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s in=%02h actual=%02h expected=%02h", req, x, got, exp);
    end
  endtask

  task automatic spot(input logic [7:0] x, input logic [7:0] exp);
    @(posedge clk);
    din = x;
    @(negedge clk);
    check("R4", x, dout, exp);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : run
    bit seen [256];
    int distinct;
    int fixed_bad;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R2: zero input after reset release
    check("R2", din, dout, 8'h63);

    // R4: known substitutions
    spot(8'h01, 8'h7C);
    spot(8'h53, 8'hED);
    spot(8'h80, 8'hCD);
    spot(8'hFF, 8'h16);
    spot(8'h10, 8'hCA);

    // R1: mid-cycle change propagates without a clock edge
    @(negedge clk);
    din = 8'h53;
    #1 check("R1", din, dout, 8'hED);
    din = 8'h00;
    #1 check("R1", din, dout, 8'h63);
    din = 8'h01;
    #1 check("R1", din, dout, 8'h7C);

    // R3 full sweep, collecting R5 and R6 evidence
    foreach (seen[i]) seen[i] = 1'b0;
    fixed_bad = 0;
    for (int k = 0; k < 256; k++) begin
      @(posedge clk);
      din = 8'(k);
      @(negedge clk);
      check((k == 0) ? "R2" : "R3", din, dout, ref_sbox(din));
      seen[dout] = 1'b1;
      if (dout == din || dout == ~din) fixed_bad++;
    end
    distinct = 0;
    foreach (seen[i]) if (seen[i]) distinct++;
    check("R5", 8'h00, 8'(distinct == 256), 8'h01);
    check("R6", 8'h00, 8'(fixed_bad), 8'h00);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule